// File: doc/BRIEF.md
# Byte/Word Arithmetic Unit with Nibble-Carry Flags

This unit is the arithmetic core of a small 8-bit processor. It takes one operation per handshake and returns a 16-bit result together with four condition flags: zero, subtract, nibble-carry (half-carry) and carry. It covers 8-bit addition and subtraction, a 16-bit register-pair addition, a 16-bit base plus signed 8-bit offset addition, 16-bit increment and decrement, and a decimal (BCD) correction step. The correction step reads the flags left behind by the previous operation.

The flags live in a register inside the unit. Each operation updates only the flags it owns, and every other flag keeps its value. As a result, a chain of operations sees the same flag history that a processor would see. Operands enter on a valid/ready input channel. Results leave on a valid/ready output channel that has a single register stage. While the result stage holds an unconsumed result and the consumer stalls (`out_ready` low), `in_ready` drops. The held result and flags do not change until they are taken. A new operation can be accepted on the same edge that the held result is consumed.

Top module: `alu_hc_core`

## Requirements
- R1: Op code 0 (byte add) gives `out_result` = {8'h00, (a[7:0]+b[7:0]) mod 256}. It sets Z when that byte is zero and clears N. It sets H on a carry out of bit 3 and C on a carry out of bit 7.
- R2: Op code 1 (byte subtract) gives {8'h00, (a[7:0]-b[7:0]) mod 256} and sets N. H is set when a[3:0] < b[3:0], which is a borrow into bit 4. C is set when a[7:0] < b[7:0], which is a borrow into bit 8. Z reflects the byte result.
- R3: Op code 2 (pair add) gives (a+b) mod 65536. It sets H on a carry out of bit 11 and C on a carry out of bit 15. It clears N and leaves Z unchanged.
- R4: Op code 3 (offset add) gives (a + sign-extended b[7:0]) mod 65536. H and C come from the unsigned addition a[7:0]+b[7:0]: H on a carry out of bit 3, C on a carry out of bit 7. Z and N are cleared.
- R5: Op code 4 (word increment) gives (a+1) mod 65536. Op code 5 (word decrement) gives (a-1) mod 65536. Neither changes any flag.
- R6: Op code 6 (decimal correct) with N clear works on a[7:0]. It adds 0x06 when H is set or the low digit is above 9. It adds 0x60 and sets C when C is set or the value is above 0x99. C is otherwise kept, H is cleared, N is kept and Z reflects the byte result.
- R7: Op code 6 with N set subtracts 0x06 when H is set and 0x60 when C is set. It keeps C and N, clears H and sets Z from the byte result.
- R8: An operation is accepted on a rising edge with `in_valid` and `in_ready` high. Its result and flags appear with `out_valid` high one cycle later. `in_ready` is high whenever `out_valid` is low or `out_ready` is high. A result not taken stays stable.
- R9: `out_flags` is {Z, N, H, C} with Z at bit 3 and C at bit 0. After reset the flags are 0, `out_valid` is 0 and `in_ready` is 1.
- R10: Op code 7 (pass) returns `a` unchanged and leaves every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present on the input channel |
| in_ready | output | 1 | Unit can accept an operation |
| in_op | input | 3 | Operation code (0 to 7) |
| in_a | input | 16 | First operand (byte ops use bits 7:0) |
| in_b | input | 16 | Second operand / offset in bits 7:0 |
| out_valid | output | 1 | Result present on the output channel |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 16 | Result of the last accepted operation |
| out_flags | output | 4 | Flags {Z, N, H, C} after that operation |

## Verification
Every result and flag set is due exactly one cycle after the edge that accepts its operation. The decimal correction uses the flags left by the operation accepted just before it, so chains of operations are run back to back. The bench drives each operation on a falling edge and lets the next rising edge accept it. It then samples `out_result` and `out_flags` on the following falling edge, once that single register stage has loaded. For the stall case, the bench holds `out_ready` low across several edges. It checks that the held result has not moved and that the queued operation shows up only in the cycle after `out_ready` returns.

// File: rtl/alu_hc_pkg.sv
package alu_hc_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int FLAG_W = 4;
  localparam int OP_W   = 3;
  localparam int WCARRY_HALF = 12;

  typedef enum logic [OP_W-1:0] {
    OP_ADD8   = 3'd0,
    OP_SUB8   = 3'd1,
    OP_ADDW   = 3'd2,
    OP_ADDOFS = 3'd3,
    OP_INCW   = 3'd4,
    OP_DECW   = 3'd5,
    OP_DADJ   = 3'd6,
    OP_PASS   = 3'd7
  } op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flags_t;
endpackage

// File: rtl/byte_arith.sv
module byte_arith
  import alu_hc_pkg::*;
(
  input  logic              do_sub,
  input  logic [BYTE_W-1:0] a,
  input  logic [BYTE_W-1:0] b,
  output logic [BYTE_W-1:0] res,
  output logic              half,
  output logic              carry
);
  logic [NIB_W:0]  lo;
  logic [BYTE_W:0] full;

  always_comb begin
    if (do_sub) begin
      lo   = {1'b0, a[NIB_W-1:0]} - {1'b0, b[NIB_W-1:0]};
      full = {1'b0, a} - {1'b0, b};
    end else begin
      lo   = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]};
      full = {1'b0, a} + {1'b0, b};
    end
    res   = full[BYTE_W-1:0];
    half  = lo[NIB_W];
    carry = full[BYTE_W];
  end
endmodule

// File: rtl/word_arith.sv
module word_arith
  import alu_hc_pkg::*;
(
  input  op_e               op,
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  output logic [WORD_W-1:0] res,
  output logic              half,
  output logic              carry
);
  localparam int EXT_W = WORD_W - BYTE_W;

  logic [WORD_W:0]        pair_sum;
  logic [WCARRY_HALF:0]   pair_low;
  logic [WORD_W-1:0]      ofs_ext;
  logic [BYTE_W:0]        ofs_byte;
  logic [NIB_W:0]         ofs_nib;

  assign ofs_ext  = {{EXT_W{b[BYTE_W-1]}}, b[BYTE_W-1:0]};
  assign pair_sum = {1'b0, a} + {1'b0, b};
  assign pair_low = {1'b0, a[WCARRY_HALF-1:0]} + {1'b0, b[WCARRY_HALF-1:0]};
  assign ofs_byte = {1'b0, a[BYTE_W-1:0]} + {1'b0, b[BYTE_W-1:0]};
  assign ofs_nib  = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]};

  always_comb begin
    res   = a;
    half  = 1'b0;
    carry = 1'b0;
    unique case (op)
      OP_ADDW: begin
        res   = pair_sum[WORD_W-1:0];
        half  = pair_low[WCARRY_HALF];
        carry = pair_sum[WORD_W];
      end
      OP_ADDOFS: begin
        res   = a + ofs_ext;
        half  = ofs_nib[NIB_W];
        carry = ofs_byte[BYTE_W];
      end
      OP_INCW: res = a + WORD_W'(1);
      OP_DECW: res = a - WORD_W'(1);
      default: res = a;
    endcase
  end
endmodule

// File: rtl/bcd_adjust.sv
module bcd_adjust
  import alu_hc_pkg::*;
(
  input  logic [BYTE_W-1:0] val,
  input  flags_t            fin,
  output logic [BYTE_W-1:0] res,
  output logic              carry
);
  localparam logic [BYTE_W-1:0] LO_FIX  = 8'h06;
  localparam logic [BYTE_W-1:0] HI_FIX  = 8'h60;
  localparam logic [BYTE_W-1:0] HI_LIM  = 8'h99;
  localparam logic [NIB_W-1:0]  DIG_LIM = 4'd9;

  logic [BYTE_W-1:0] corr;

  always_comb begin
    corr  = '0;
    carry = fin.c;
    if (!fin.n) begin
      if (fin.h || (val[NIB_W-1:0] > DIG_LIM)) corr = corr | LO_FIX;
      if (fin.c || (val > HI_LIM)) begin
        corr  = corr | HI_FIX;
        carry = 1'b1;
      end
      res = val + corr;
    end else begin
      if (fin.h) corr = corr | LO_FIX;
      if (fin.c) corr = corr | HI_FIX;
      res = val - corr;
    end
  end
endmodule

// File: rtl/alu_hc_core.sv
module alu_hc_core
  import alu_hc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_op,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_result,
  output logic [FLAG_W-1:0] out_flags
);
  op_e               op;
  flags_t            flag_q, flag_d;
  logic [WORD_W-1:0] res_q, res_d;
  logic              vld_q, accept;

  logic [BYTE_W-1:0] b_res, d_res;
  logic              b_h, b_c, d_c;
  logic [WORD_W-1:0] w_res;
  logic              w_h, w_c;

  assign op       = op_e'(in_op);
  assign in_ready = !vld_q || out_ready;
  assign accept   = in_valid && in_ready;

  byte_arith u_byte (
    .do_sub (op == OP_SUB8),
    .a      (in_a[BYTE_W-1:0]),
    .b      (in_b[BYTE_W-1:0]),
    .res    (b_res),
    .half   (b_h),
    .carry  (b_c)
  );

  word_arith u_word (
    .op    (op),
    .a     (in_a),
    .b     (in_b),
    .res   (w_res),
    .half  (w_h),
    .carry (w_c)
  );

  bcd_adjust u_bcd (
    .val   (in_a[BYTE_W-1:0]),
    .fin   (flag_q),
    .res   (d_res),
    .carry (d_c)
  );

  always_comb begin
    flag_d = flag_q;
    res_d  = in_a;
    unique case (op)
      OP_ADD8, OP_SUB8: begin
        res_d    = {{(WORD_W-BYTE_W){1'b0}}, b_res};
        flag_d.z = (b_res == '0);
        flag_d.n = (op == OP_SUB8);
        flag_d.h = b_h;
        flag_d.c = b_c;
      end
      OP_ADDW: begin
        res_d    = w_res;
        flag_d.n = 1'b0;
        flag_d.h = w_h;
        flag_d.c = w_c;
      end
      OP_ADDOFS: begin
        res_d    = w_res;
        flag_d.z = 1'b0;
        flag_d.n = 1'b0;
        flag_d.h = w_h;
        flag_d.c = w_c;
      end
      OP_INCW, OP_DECW: res_d = w_res;
      OP_DADJ: begin
        res_d    = {{(WORD_W-BYTE_W){1'b0}}, d_res};
        flag_d.z = (d_res == '0);
        flag_d.h = 1'b0;
        flag_d.c = d_c;
      end
      default: res_d = in_a;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      res_q  <= '0;
      flag_q <= '0;
    end else begin
      if (accept) begin
        vld_q  <= 1'b1;
        res_q  <= res_d;
        flag_q <= flag_d;
      end else if (out_ready) begin
        vld_q <= 1'b0;
      end
    end
  end

  assign out_valid  = vld_q;
  assign out_result = res_q;
  assign out_flags  = flag_q;
endmodule

// File: rtl/alu_hc_checker.sv
module alu_hc_checker
  import alu_hc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [OP_W-1:0]   in_op,
  input logic [WORD_W-1:0] in_a,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_result,
  input logic [FLAG_W-1:0] out_flags
);
  logic acc;
  assign acc = in_valid && in_ready;

  assert_ready_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  assert_result_due_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_flags)));

  assert_sub_sets_n_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == OP_SUB8) |=> out_flags[2]);

  assert_pair_keeps_z_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == OP_ADDW) |=> (out_flags[3] == $past(out_flags[3]) && !out_flags[2]));

  assert_ofs_clears_zn_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == OP_ADDOFS) |=> (!out_flags[3] && !out_flags[2]));

  assert_incdec_no_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_op == OP_INCW || in_op == OP_DECW)) |=> $stable(out_flags));

  assert_dadj_clears_h_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == OP_DADJ) |=> (!out_flags[1] && out_flags[2] == $past(out_flags[2])));

  assert_pass_through_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == OP_PASS) |=> (out_result == $past(in_a) && $stable(out_flags)));
endmodule

bind alu_hc_core alu_hc_checker u_alu_hc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_op      (in_op),
  .in_a       (in_a),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_flags  (out_flags)
);

// File: tb/alu_hc_core_bench.sv
module alu_hc_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = 3'd0;
  logic [15:0] in_a = 16'h0;
  logic [15:0] in_b = 16'h0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_result;
  logic [3:0]  out_flags;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [3:0] mflags = 4'h0;

  always #2 clk = ~clk;

  alu_hc_core u_alu_hc_core (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_flags(out_flags)
  );

  function automatic string req_of(input logic [2:0] op, input logic n);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4, 3'd5: return "R5";
      3'd6: return n ? "R7" : "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Reference model; flags {Z,N,H,C}
  task automatic model(input logic [2:0] op, input int a, input int b,
                       output int res, output logic [3:0] f);
    int z = mflags[3], n = mflags[2], h = mflags[1], c = mflags[0];
    int lo, v, ofs;
    case (op)
      3'd0: begin
        res = ((a % 256) + (b % 256)) % 256;
        h = (((a % 16) + (b % 16)) > 15) ? 1 : 0;
        c = (((a % 256) + (b % 256)) > 255) ? 1 : 0;
        n = 0; z = (res == 0) ? 1 : 0;
      end
      3'd1: begin
        res = ((a % 256) - (b % 256) + 256) % 256;
        h = ((a % 16) < (b % 16)) ? 1 : 0;
        c = ((a % 256) < (b % 256)) ? 1 : 0;
        n = 1; z = (res == 0) ? 1 : 0;
      end
      3'd2: begin
        res = (a + b) % 65536;
        h = (((a % 4096) + (b % 4096)) > 4095) ? 1 : 0;
        c = ((a + b) > 65535) ? 1 : 0;
        n = 0;
      end
      3'd3: begin
        ofs = b % 256;
        if (ofs > 127) ofs = ofs - 256;
        res = (a + ofs + 65536) % 65536;
        h = (((a % 16) + (b % 16)) > 15) ? 1 : 0;
        c = (((a % 256) + (b % 256)) > 255) ? 1 : 0;
        z = 0; n = 0;
      end
      3'd4: res = (a + 1) % 65536;
      3'd5: res = (a + 65535) % 65536;
      3'd6: begin
        v = a % 256;
        lo = 0;
        if (n == 0) begin
          if (h == 1 || (v % 16) > 9) lo = lo + 6;
          if (c == 1 || v > 153) begin lo = lo + 96; c = 1; end
          res = (v + lo) % 256;
        end else begin
          if (h == 1) lo = lo + 6;
          if (c == 1) lo = lo + 96;
          res = (v - lo + 256) % 256;
        end
        h = 0; z = (res == 0) ? 1 : 0;
      end
      default: res = a;
    endcase
    f = {z[0], n[0], h[0], c[0]};
  endtask

  task automatic run_op(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b);
    int er;
    logic [3:0] ef;
    string rq;
    rq = req_of(op, mflags[2]);
    model(op, int'(a), int'(b), er, ef);
    @(negedge clk);
    in_op = op; in_a = a; in_b = b; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check({rq, " valid"}, int'(out_valid), 1);
    check({rq, " result"}, int'(out_result), er);
    check({rq, " flags"}, int'(out_flags), int'(ef));
    mflags = ef;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int er;
    logic [3:0] ef;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    check("R9 out_valid after reset", int'(out_valid), 0);
    check("R9 in_ready after reset", int'(in_ready), 1);
    check("R9 flags after reset", int'(out_flags), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 byte add corners
    run_op(3'd0, 16'h000F, 16'h0001);   // 0x10, H
    run_op(3'd0, 16'h00FF, 16'h0001);   // 0x00, Z H C
    run_op(3'd0, 16'h1234, 16'hAB10);   // upper bytes ignored
    // R2 byte subtract corners
    run_op(3'd1, 16'h0010, 16'h0001);   // 0x0F, N H
    run_op(3'd1, 16'h0000, 16'h0001);   // 0xFF, N H C
    run_op(3'd1, 16'h0055, 16'h0055);   // zero
    // R3 pair add keeps Z (Z currently 1)
    run_op(3'd2, 16'h0FFF, 16'h0001);   // H from bit 11
    run_op(3'd2, 16'h8000, 16'h8000);   // result 0, C, Z kept
    run_op(3'd0, 16'h0001, 16'h0001);   // clear Z
    run_op(3'd2, 16'h8000, 16'h8000);   // result 0, Z stays 0
    // R4 offset add
    run_op(3'd3, 16'h00FF, 16'h0001);
    run_op(3'd3, 16'h1000, 16'h00FF);   // minus one
    run_op(3'd3, 16'hFFF8, 16'h0088);   // negative offset with carries
    // R5 increment/decrement wrap, flags kept
    run_op(3'd1, 16'h0000, 16'h0001);   // set N H C
    run_op(3'd5, 16'h0000, 16'h0000);
    run_op(3'd4, 16'hFFFF, 16'h0000);
    // R10 pass
    run_op(3'd7, 16'hBEEF, 16'h1234);
    // R6 decimal correct after add
    run_op(3'd0, 16'h0015, 16'h0027);
    run_op(3'd6, 16'h003C, 16'h0000);   // 0x42
    run_op(3'd0, 16'h0099, 16'h0001);
    run_op(3'd6, 16'h009A, 16'h0000);   // 0x00, C, Z
    run_op(3'd0, 16'h0009, 16'h0009);   // 0x12 with H
    run_op(3'd6, 16'h0012, 16'h0000);   // 0x18
    // R7 decimal correct after subtract
    run_op(3'd1, 16'h0042, 16'h0015);
    run_op(3'd6, 16'h002D, 16'h0000);   // 0x27
    run_op(3'd1, 16'h0010, 16'h0020);   // 0xF0 with C
    run_op(3'd6, 16'h00F0, 16'h0000);   // 0x90, C kept

    // R8 stall: result held, operation waits
    run_op(3'd0, 16'h0011, 16'h0022);
    @(negedge clk);
    out_ready = 1'b0;
    @(negedge clk);               // output empty now; load one result
    in_op = 3'd2; in_a = 16'h1111; in_b = 16'h2222; in_valid = 1'b1;
    model(3'd2, 16'h1111, 16'h2222, er, ef);
    @(posedge clk); @(negedge clk);
    mflags = ef;
    in_op = 3'd7; in_a = 16'h5A5A;
    check("R8 first result under stall", int'(out_result), er);
    check("R8 in_ready low while held", int'(in_ready), 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 result held", int'(out_result), er);
    check("R8 flags held", int'(out_flags), int'(ef));
    check("R8 valid held", int'(out_valid), 1);
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    check("R8 queued op accepted", int'(out_result), 16'h5A5A);
    check("R10 flags after pass", int'(out_flags), int'(mflags));
    @(negedge clk);
    check("R8 valid drops when drained", int'(out_valid), 0);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      run_op(3'($urandom_range(0, 7)), 16'($urandom), 16'($urandom));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule